// File: doc/BRIEF.md
# Channel Status Flag and Block-Start Extractor

This block sits behind a biphase decoder in a digital audio receiver. For every received subframe it gets one strobe, together with the subframe's channel (left or right), a mark for the block-start preamble, and that subframe's channel-status bit and user bit. It re-times both bit streams onto two serial outputs. It also raises a block-start window at the start of each 192-frame status block. From the first status byte of the left channel it decodes an emphasis flag and an audio/non-audio flag.

All outputs are taken from a single delay line of `DELAY` clocks, so the serial bits, the block window and the flags stay aligned with each other. The clock is the receiver's bit clock. The flags are decoded once per block, and only from left-channel status. The professional/consumer bit (status bit 0) chooses which emphasis code applies. No CRC is checked.

Top module: `cstat_extract`

## Requirements
- R1: While `rstN` is low, all five outputs are low. They stay low after reset until a delayed subframe changes them.
- R2: `nonAudioFlag` is loaded with status bit 1 of the left channel (1 = non-audio data). Status bit n is the channel-status bit of the left subframe of frame n of the block, where frame 0 is the frame opened by the block-start subframe.
- R3: When status bit 0 is 1 (professional), `emphFlag` is loaded with 1 only if bit 2 = 1, bit 3 = 1 and bit 4 = 0. Otherwise it is loaded with 0.
- R4: When status bit 0 is 0 (consumer), `emphFlag` is loaded with 1 only if bit 3 = 1, bit 4 = 0 and bit 5 = 0. Otherwise it is loaded with 0.
- R5: Both flags are loaded only when the left subframe of frame 7 of a block is processed. They hold their value until the next such load. Right-channel status bits never affect them, and nothing is loaded before the first block start.
- R6: The channel-status and user bits of every subframe, left and right alternately in arrival order, appear on `csSerial` and `userSerial` exactly `DELAY` clocks after the strobe is sampled. They hold until the next subframe is due.
- R7: `blockFlag` rises `DELAY` clocks after a left subframe marked as block start is sampled. It stays high for 32 frames and falls `DELAY` clocks after the left subframe of frame 32 is sampled. A block-start mark on a right subframe is ignored.
- R8: The frame position counts left subframes from the block start and stops at frame 191 if no new block start arrives. A new block start at any position restarts the count at frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| subStrobe | input | 1 | One-clock pulse per received subframe |
| subRight | input | 1 | Channel of the subframe: 0 left, 1 right |
| subBlockStart | input | 1 | Subframe carried the block-start preamble |
| subCs | input | 1 | Channel-status bit of the subframe |
| subUser | input | 1 | User bit of the subframe |
| csSerial | output | 1 | Delayed serial channel-status stream |
| userSerial | output | 1 | Delayed serial user stream |
| blockFlag | output | 1 | High for the first 32 frames of each block |
| emphFlag | output | 1 | Decoded emphasis flag |
| nonAudioFlag | output | 1 | Decoded non-audio flag |

## Verification
Directed blocks feed left status bytes that carry each emphasis code under both values of the mode bit, together with near-miss codes that differ in one bit. This separates the professional decode from the consumer decode. In those blocks the right channel carries the opposite bytes, which shows whether the right channel leaks into the flags. Further cases are a stream before any block start, a block-start mark on a right subframe, a 200-frame block that drives the frame count to its limit, and short blocks that restart while the window is still high; these show the window timing and the restart behaviour. Random blocks with random lengths, random bits and random gaps between strobes check that every bit lands `DELAY` clocks after its strobe, whatever the subframe spacing.

// File: rtl/cstat_pkg.sv
package cstat_pkg;

  // one received subframe as it moves down the delay line
  typedef struct packed {
    logic strobe;
    logic right;
    logic start;
    logic cs;
    logic user;
  } subT;

  // strobes from control to datapath
  typedef struct packed {
    logic       serLoad;
    logic       capEn;
    logic [2:0] capPos;
    logic       flagLoad;
  } ctlT;

  // emphasis code depends on the professional/consumer bit
  function automatic logic emphDecode(input logic [7:0] b);
    if (b[0]) return b[2] & b[3] & ~b[4];
    else      return b[3] & ~b[4] & ~b[5];
  endfunction

endpackage

// File: rtl/cstat_dpath.sv
module cstat_dpath
  import cstat_pkg::*;
#(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rstN,
  input  subT  subIn,
  input  ctlT  ctl,
  output logic dlyStrobe,
  output logic dlyRight,
  output logic dlyStart,
  output logic csSerial,
  output logic userSerial,
  output logic emphFlag,
  output logic nonAudioFlag
);

  // delay line, one register per generate stage
  for (genvar g = 0; g < DELAY; g++) begin : gStage
    subT q;
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= subIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= gStage[g-1].q;
      end
    end
  end

  subT tail;
  assign tail      = gStage[DELAY-1].q;
  assign dlyStrobe = tail.strobe;
  assign dlyRight  = tail.right;
  assign dlyStart  = tail.start;

  logic [7:0] statByte;
  logic [7:0] statNext;

  always_comb begin
    statNext = statByte;
    statNext[ctl.capPos] = tail.cs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statByte     <= '0;
      csSerial     <= 1'b0;
      userSerial   <= 1'b0;
      emphFlag     <= 1'b0;
      nonAudioFlag <= 1'b0;
    end else begin
      if (ctl.serLoad) begin
        csSerial   <= tail.cs;
        userSerial <= tail.user;
      end
      if (ctl.capEn) statByte <= statNext;
      if (ctl.flagLoad) begin
        emphFlag     <= emphDecode(statNext);
        nonAudioFlag <= statNext[1];
      end
    end
  end

endmodule

// File: rtl/cstat_ctrl.sv
module cstat_ctrl
  import cstat_pkg::*;
#(
  parameter int FRAMES      = 192,
  parameter int HIGH_FRAMES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic dlyStrobe,
  input  logic dlyRight,
  input  logic dlyStart,
  output ctlT  ctl,
  output logic blockFlag
);

  localparam int IDXW = $clog2(FRAMES);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAMES - 1);
  localparam logic [IDXW-1:0] HIGH_IDX = IDXW'(HIGH_FRAMES);
  localparam logic [IDXW-1:0] BYTE_END = IDXW'(8);
  localparam logic [IDXW-1:0] LOAD_IDX = IDXW'(7);

  logic            inBlock;
  logic [IDXW-1:0] frameIdx;
  logic            nextIn;
  logic [IDXW-1:0] nextIdx;
  logic            advance;
  logic            leftSub;

  always_comb begin
    leftSub = dlyStrobe & ~dlyRight;
    nextIn  = inBlock;
    nextIdx = frameIdx;
    advance = 1'b0;
    if (leftSub && dlyStart) begin
      nextIn  = 1'b1;
      nextIdx = '0;
      advance = 1'b1;
    end else if (leftSub && inBlock && frameIdx < LAST_IDX) begin
      nextIdx = frameIdx + 1'b1;
      advance = 1'b1;
    end
  end

  always_comb begin
    ctl.serLoad  = dlyStrobe;
    ctl.capEn    = advance && (nextIdx < BYTE_END);
    ctl.capPos   = nextIdx[2:0];
    ctl.flagLoad = advance && (nextIdx == LOAD_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBlock   <= 1'b0;
      frameIdx  <= '0;
      blockFlag <= 1'b0;
    end else begin
      inBlock   <= nextIn;
      frameIdx  <= nextIdx;
      blockFlag <= nextIn && (nextIdx < HIGH_IDX);
    end
  end

endmodule

// File: rtl/cstat_extract.sv
module cstat_extract
  import cstat_pkg::*;
#(
  parameter int DELAY       = 16,
  parameter int FRAMES      = 192,
  parameter int HIGH_FRAMES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic subStrobe,
  input  logic subRight,
  input  logic subBlockStart,
  input  logic subCs,
  input  logic subUser,
  output logic csSerial,
  output logic userSerial,
  output logic blockFlag,
  output logic emphFlag,
  output logic nonAudioFlag
);

  subT  subIn;
  ctlT  ctlStb;
  logic dlyStrobe;
  logic dlyRight;
  logic dlyStart;

  assign subIn = '{strobe: subStrobe, right: subRight, start: subBlockStart,
                   cs: subCs, user: subUser};

  cstat_dpath #(.DELAY(DELAY)) uDpath (
    .clk(clk), .rstN(rstN), .subIn(subIn), .ctl(ctlStb),
    .dlyStrobe(dlyStrobe), .dlyRight(dlyRight), .dlyStart(dlyStart),
    .csSerial(csSerial), .userSerial(userSerial),
    .emphFlag(emphFlag), .nonAudioFlag(nonAudioFlag)
  );

  cstat_ctrl #(.FRAMES(FRAMES), .HIGH_FRAMES(HIGH_FRAMES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .dlyStrobe(dlyStrobe), .dlyRight(dlyRight), .dlyStart(dlyStart),
    .ctl(ctlStb), .blockFlag(blockFlag)
  );

endmodule

// File: rtl/cstat_chk.sv
module cstat_chk (
  input logic clk,
  input logic rstN,
  input logic dlyStrobe,
  input logic dlyRight,
  input logic dlyStart,
  input logic ctlFlagLoad,
  input logic csSerial,
  input logic userSerial,
  input logic blockFlag,
  input logic emphFlag,
  input logic nonAudioFlag
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_low_R1: assert ({csSerial, userSerial, blockFlag, emphFlag, nonAudioFlag} == 5'b0);
    end
  end

  assert_blk_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockFlag) |-> $past(dlyStrobe && !dlyRight && dlyStart));

  assert_blk_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(blockFlag) |-> $past(dlyStrobe && !dlyRight));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctlFlagLoad) |-> ($stable(emphFlag) && $stable(nonAudioFlag)));

  assert_ser_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dlyStrobe) |-> ($stable(csSerial) && $stable(userSerial)));

endmodule

bind cstat_extract cstat_chk uChk (
  .clk(clk), .rstN(rstN),
  .dlyStrobe(dlyStrobe), .dlyRight(dlyRight), .dlyStart(dlyStart),
  .ctlFlagLoad(ctlStb.flagLoad),
  .csSerial(csSerial), .userSerial(userSerial), .blockFlag(blockFlag),
  .emphFlag(emphFlag), .nonAudioFlag(nonAudioFlag)
);

// File: tb/cstat_extract_test.sv
`timescale 1ns/1ps
module cstat_extract_test;

  localparam int DELAY = 16;

  logic clk = 0, rstN = 0;
  logic subStrobe = 0, subRight = 0, subBlockStart = 0, subCs = 0, subUser = 0;
  logic csSerial, userSerial, blockFlag, emphFlag, nonAudioFlag;

  cstat_extract uut (
    .clk(clk), .rstN(rstN), .subStrobe(subStrobe), .subRight(subRight),
    .subBlockStart(subBlockStart), .subCs(subCs), .subUser(subUser),
    .csSerial(csSerial), .userSerial(userSerial), .blockFlag(blockFlag),
    .emphFlag(emphFlag), .nonAudioFlag(nonAudioFlag)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state, built from the requirements
  bit       mIn = 0;
  int       mIdx = 0;
  bit [7:0] mByte = 0;
  bit       mEmph = 0, mNa = 0, mPro = 0;

  int qCyc [64];
  bit qCs [64], qU [64], qBlk [64], qEmph [64], qNa [64], qPro [64];
  int sent = 0, chk = 0, e = 0;

  function automatic bit emphRef(bit [7:0] b);
    if (b[0] == 1'b1) return (b[4:2] == 3'b011);
    return (b[5:3] == 3'b001);
  endfunction

  task automatic check(bit got, bit exp, string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b cycle=%0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk < sent && qCyc[chk % 64] + 1 + DELAY == cyc) begin
      e = chk % 64;
      check(csSerial,   qCs[e], "R6 csSerial");
      check(userSerial, qU[e],  "R6 userSerial");
      check(blockFlag,  qBlk[e], "R7/R8 blockFlag");
      check(nonAudioFlag, qNa[e], "R2/R5 nonAudioFlag");
      if (qPro[e]) check(emphFlag, qEmph[e], "R3/R5 emphFlag");
      else         check(emphFlag, qEmph[e], "R4/R5 emphFlag");
      chk++;
    end
  end

  task automatic sendSub(bit right, bit start, bit cs, bit u, int gap);
    bit adv;
    @(negedge clk);
    subStrobe = 1; subRight = right; subBlockStart = start; subCs = cs; subUser = u;
    adv = 0;
    if (!right && start) begin mIn = 1; mIdx = 0; adv = 1; end
    else if (!right && mIn && mIdx < 191) begin mIdx++; adv = 1; end
    if (adv && mIdx < 8) begin
      mByte[mIdx] = cs;
      if (mIdx == 7) begin mEmph = emphRef(mByte); mNa = mByte[1]; mPro = mByte[0]; end
    end
    qCyc[sent % 64] = cyc; qCs[sent % 64] = cs; qU[sent % 64] = u;
    qBlk[sent % 64] = mIn && (mIdx < 32);
    qEmph[sent % 64] = mEmph; qNa[sent % 64] = mNa; qPro[sent % 64] = mPro;
    sent++;
    @(negedge clk);
    subStrobe = 0; subBlockStart = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sendFrame(bit startL, bit startR, bit cl, bit ul, bit cr, bit ur);
    sendSub(0, startL, cl, ul, $urandom_range(0, 3));
    sendSub(1, startR, cr, ur, $urandom_range(0, 3));
  endtask

  task automatic sendBlock(bit [7:0] lByte, bit [7:0] rByte, int frames, bit rightNoise);
    for (int f = 0; f < frames; f++) begin
      bit cl, cr;
      cl = (f < 8) ? lByte[f] : 1'($urandom);
      cr = (f < 8) ? rByte[f] : 1'($urandom);
      sendFrame(f == 0, rightNoise && (f == 3), cl, 1'($urandom), cr, 1'($urandom));
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1357);
    // R1: reset state
    repeat (3) @(negedge clk);
    check(csSerial | userSerial | blockFlag | emphFlag | nonAudioFlag, 1'b0, "R1 outputs in reset");
    rstN = 1;
    repeat (3) @(negedge clk);
    check(csSerial | userSerial | blockFlag | emphFlag | nonAudioFlag, 1'b0, "R1 outputs after reset");

    // before any block start; right-side start mark ignored (R7)
    sendFrame(0, 0, 1, 1, 0, 1);
    sendFrame(0, 1, 1, 0, 1, 1);
    sendFrame(0, 0, 0, 1, 1, 0);

    // professional emphasis, right channel opposite (R3, R5)
    sendBlock(8'h0D, 8'hF2, 40, 1);
    // professional, bit 4 set, non-audio (R3, R2)
    sendBlock(8'h1F, 8'h0D, 36, 0);
    // professional near miss: bit 2 clear
    sendBlock(8'h09, 8'h0D, 34, 0);
    // consumer emphasis (R4)
    sendBlock(8'h08, 8'h0D, 34, 0);
    // consumer emphasis plus non-audio
    sendBlock(8'h0A, 8'h00, 34, 1);
    // consumer near misses
    sendBlock(8'h18, 8'h08, 33, 0);
    sendBlock(8'h28, 8'h08, 33, 0);
    // short block restarted inside the high window (R8)
    sendBlock(8'h08, 8'h00, 10, 0);
    // long block: count stops at 191 (R8)
    sendBlock(8'h0D, 8'h08, 200, 0);

    // random blocks
    for (int b = 0; b < 10; b++) begin
      sendBlock(8'($urandom), 8'($urandom), $urandom_range(5, 120), 1'($urandom));
    end

    repeat (DELAY + 6) @(negedge clk);
    check(chk == sent, 1'b1, "R6 all subframes emitted");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule